// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block is the host-side master for a three-wire serial EEPROM. The wires are a chip enable, a serial clock, a data line toward the memory and a data line back from it. A host gives the block a one-cycle start pulse with a 2-bit operation code and a 6-bit word address. The block builds a 9-bit command frame, shifts it out most significant bit first and, for a read, clocks in one 16-bit word. It then closes the transaction and pulses done. On a read, the word appears on the read-data output.

Every clock phase lasts `HALF_CYCLES` system clocks. An override flag, `man_o`, is high for the whole access. While it is low the serial pins are parked. The controller is a single state machine with these states:

- `ST_IDLE`: pins parked. A start pulse moves it to `ST_ARM`.
- `ST_ARM`: enable and clock are held low under override.
- `ST_TX_LO` and `ST_TX_HI`: one output bit. The data line is set in `ST_TX_LO` and the clock is high in `ST_TX_HI`. The next step depends on what has been sent:
  - After a bit that is not the last, it returns to `ST_TX_LO`.
  - After the last bit of a read, it goes to `ST_TX_TAIL`.
  - After the last bit of any other command, it goes to `ST_STOP`.
- `ST_TX_TAIL`: a low clock phase between the command and the data.
- `ST_RX_HI` and `ST_RX_LO`: one input bit. The data line is sampled at the end of `ST_RX_LO`. After 16 bits it goes to `ST_STOP`.
- `ST_STOP`: enable low, data line high. It then returns to `ST_IDLE` and pulses done.

Top module: `uwire_cmd_master`

## Requirements
- R1: The frame is 9 bits, sent MSB first. In order it carries a start bit of 1, then `op_i` (2 bits), then `addr_i` (6 bits). The codes for `op_i` are:
  - 2'b10 read, giving 0x180+addr.
  - 2'b01 write, giving 0x140+addr.
  - 2'b11 erase, giving 0x1C0+addr.
  - 2'b00 extended group, giving 0x100+addr. For this code `addr_i` carries the sub-code: 0x00 disable writes, 0x10 write all, 0x20 erase all, 0x30 enable writes.
- R2: When an access begins, `man_o` rises while `cs_o` and `sk_o` are low. They stay low for `HALF_CYCLES` clocks, and only then does `cs_o` rise. `cs_o` stays high through the whole command and any read data.
- R3: For each outgoing bit, `di_o` is set first. `sk_o` rises `HALF_CYCLES` clocks later and falls after another `HALF_CYCLES`. `di_o` does not change while `sk_o` is high.
- R4: On a read, exactly 16 more clock pulses follow the command. `do_i` is sampled after each falling edge and the bits are assembled MSB first. The word appears on `rdata_o` when `done_o` pulses.
- R5: Write, erase and extended commands produce exactly 9 clock pulses and no data phase, and leave `rdata_o` unchanged.
- R6: At the end of an access `cs_o` drops with `di_o` high. `done_o` then pulses for one cycle, in which `busy_o` is already low.
- R7: `man_o` is high from the cycle after the start is accepted until the access ends. Whenever `man_o` is low, `cs_o`=0, `sk_o`=0 and `di_o`=1.
- R8: A start pulse that arrives while `busy_o` is high is ignored. The frame in progress is unchanged and no further access follows. A start during the done cycle is accepted.
- R9: After reset the block is idle: `busy_o`=0, `done_o`=0, `rdata_o`=0, and the pins are parked.
- R10: Every high phase of `sk_o` lasts exactly `HALF_CYCLES` system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin an access |
| op_i | input | 2 | Operation code (read, write, erase, extended) |
| addr_i | input | 6 | Word address or extended sub-code |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle end-of-access pulse |
| rdata_o | output | 16 | Last word read |
| man_o | output | 1 | Pin override, high during an access |
| cs_o | output | 1 | EEPROM chip enable |
| sk_o | output | 1 | EEPROM serial clock |
| di_o | output | 1 | Serial data toward the EEPROM |
| do_i | input | 1 | Serial data from the EEPROM |

## Verification
Two events can coincide in one cycle: the end of one access, signalled by `done_o`, and the acceptance of the next start. The bench often issues the next start in exactly the cycle where `done_o` is seen. It then checks that `busy_o` rises and that the new frame is captured in full. As a counterpart, it also injects a start in the middle of a busy access. It judges that case by the frame bits, the pulse count, and by `man_o` staying low after done.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } uw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_TX_LO,
        ST_TX_HI,
        ST_TX_TAIL,
        ST_RX_HI,
        ST_RX_LO,
        ST_STOP
    } uw_state_e;

endpackage

// File: rtl/uw_half_timer.sv
module uw_half_timer #(
    parameter int HALF_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/uw_shift_reg.sv
module uw_shift_reg #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             shift_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_o <= '0;
        else if (load_i)
            q_o <= load_val_i;
        else if (shift_i)
            q_o <= {q_o[WIDTH-2:0], ser_i};
    end
endmodule

// File: rtl/uwire_cmd_master.sv
module uwire_cmd_master
    import uwire_pkg::*;
#(
    parameter int HALF_CYCLES = 5,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              man_o,
    output logic              cs_o,
    output logic              sk_o,
    output logic              di_o,
    input  logic              do_i
);
    localparam int CMD_W = 1 + 2 + ADDR_W;
    localparam int MAX_W = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int BIT_W = $clog2(MAX_W);
    localparam logic [BIT_W-1:0] CMD_LAST  = BIT_W'(CMD_W - 1);
    localparam logic [BIT_W-1:0] DATA_LAST = BIT_W'(DATA_W - 1);

    uw_state_e         state_q, state_d;
    logic [BIT_W-1:0]  bit_q;
    logic              read_q;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;
    logic              tick;
    logic              accept;
    logic [CMD_W-1:0]  tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              tx_shift, rx_shift;

    assign accept = (state_q == ST_IDLE) && start_i;

    uw_half_timer #(.HALF_CYCLES(HALF_CYCLES)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q != ST_IDLE),
        .tick_o (tick)
    );

    assign tx_shift = (state_q == ST_TX_HI) && tick && (bit_q != CMD_LAST);

    uw_shift_reg #(.WIDTH(CMD_W)) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i ({1'b1, op_i, addr_i}),
        .shift_i    (tx_shift),
        .ser_i      (1'b0),
        .q_o        (tx_q)
    );

    assign rx_shift = (state_q == ST_RX_LO) && tick;

    uw_shift_reg #(.WIDTH(DATA_W)) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i ('0),
        .shift_i    (rx_shift),
        .ser_i      (do_i),
        .q_o        (rx_q)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_ARM;
            ST_ARM:     if (tick) state_d = ST_TX_LO;
            ST_TX_LO:   if (tick) state_d = ST_TX_HI;
            ST_TX_HI:   if (tick) begin
                            if (bit_q != CMD_LAST) state_d = ST_TX_LO;
                            else if (read_q)       state_d = ST_TX_TAIL;
                            else                   state_d = ST_STOP;
                        end
            ST_TX_TAIL: if (tick) state_d = ST_RX_HI;
            ST_RX_HI:   if (tick) state_d = ST_RX_LO;
            ST_RX_LO:   if (tick) state_d = (bit_q == DATA_LAST) ? ST_STOP : ST_RX_HI;
            ST_STOP:    if (tick) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and transaction bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            read_q  <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_STOP) && tick;
            if (accept) begin
                bit_q  <= '0;
                read_q <= (uw_op_e'(op_i) == OP_READ);
            end else if (tick && (state_q == ST_TX_HI || state_q == ST_RX_LO)) begin
                if (state_d == ST_TX_LO || state_d == ST_RX_HI)
                    bit_q <= bit_q + 1'b1;
                else
                    bit_q <= '0;
            end
            if ((state_q == ST_STOP) && tick && read_q)
                rdata_q <= rx_q;
        end
    end

    // pin and status outputs
    always_comb begin
        man_o = 1'b1;
        cs_o  = 1'b0;
        sk_o  = 1'b0;
        di_o  = 1'b1;
        unique case (state_q)
            ST_IDLE:    man_o = 1'b0;
            ST_ARM:     ;
            ST_TX_LO:   begin cs_o = 1'b1; di_o = tx_q[CMD_W-1]; end
            ST_TX_HI:   begin cs_o = 1'b1; sk_o = 1'b1; di_o = tx_q[CMD_W-1]; end
            ST_TX_TAIL: begin cs_o = 1'b1; di_o = tx_q[CMD_W-1]; end
            ST_RX_HI:   begin cs_o = 1'b1; sk_o = 1'b1; di_o = tx_q[CMD_W-1]; end
            ST_RX_LO:   begin cs_o = 1'b1; di_o = tx_q[CMD_W-1]; end
            ST_STOP:    ;
            default:    man_o = 1'b0;
        endcase
    end

    assign busy_o  = (state_q != ST_IDLE);
    assign done_o  = done_q;
    assign rdata_o = rdata_q;
endmodule

// File: rtl/uwire_cmd_master_chk.sv
module uwire_cmd_master_chk #(
    parameter int HALF_CYCLES = 5
) (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic man_o,
    input logic cs_o,
    input logic sk_o,
    input logic di_o
);
    logic [31:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hi_cnt <= '0;
        else if (sk_o) hi_cnt <= hi_cnt + 1;
        else           hi_cnt <= '0;
    end

    a_r7_parked_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !man_o |-> (!cs_o && !sk_o && di_o));

    a_r2_clock_inside_enable: assert property (@(posedge clk) disable iff (!rst_n)
        sk_o |-> cs_o);

    a_r2_enable_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_o) |-> ($past(man_o) && !$past(sk_o)));

    a_r3_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_o && $past(sk_o)) |-> $stable(di_o));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_done_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !cs_o && di_o));

    a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r10_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sk_o) |-> (hi_cnt == HALF_CYCLES));
endmodule

bind uwire_cmd_master uwire_cmd_master_chk #(.HALF_CYCLES(HALF_CYCLES)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_o (busy_o),
    .done_o (done_o),
    .man_o  (man_o),
    .cs_o   (cs_o),
    .sk_o   (sk_o),
    .di_o   (di_o)
);

// File: tb/uwire_cmd_master_tb_top.sv
module uwire_cmd_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [5:0]  addr_i = 6'd0;
    logic        busy_o, done_o, man_o, cs_o, sk_o, di_o;
    logic [15:0] rdata_o;
    logic        do_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // monitor state
    int          edge_cnt = 0;
    logic [8:0]  frame = '0;
    logic [15:0] cur_word = '0;
    int          hi_run = 0, hmin = 1000, hmax = 0;
    int          pre_cnt = 0;
    bit          cs_seen = 0;
    bit          arm_ok = 1;
    bit          sk_prev = 0, man_prev = 0;
    logic [15:0] exp_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uwire_cmd_master #(.HALF_CYCLES(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .man_o(man_o),
        .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o), .do_i(do_i)
    );

    function automatic logic [15:0] mem_word(input logic [5:0] a);
        return {a, a[3:0], a} ^ 16'h5AC3;
    endfunction

    function automatic logic [8:0] exp_frame(input logic [1:0] op, input logic [5:0] a);
        logic [8:0] base;
        case (op)
            2'b10:   base = 9'h180;
            2'b01:   base = 9'h140;
            2'b11:   base = 9'h1C0;
            default: base = 9'h100;
        endcase
        return base + {3'b000, a};
    endfunction

    // EEPROM model: capture command bits, present read data on rising clock edges
    always @(posedge sk_o) begin
        if (edge_cnt < 9) frame = {frame[7:0], di_o};
        else if (edge_cnt < 25) do_i = cur_word[15 - (edge_cnt - 9)];
        edge_cnt = edge_cnt + 1;
    end

    // cycle monitor for clock widths and the arming phase
    always @(negedge clk) begin
        if (sk_o) hi_run = hi_run + 1;
        else if (sk_prev) begin
            if (hi_run < hmin) hmin = hi_run;
            if (hi_run > hmax) hmax = hi_run;
            hi_run = 0;
        end
        if (man_o && !man_prev && (cs_o || sk_o)) arm_ok = 0;
        if (man_o && !cs_o && !cs_seen) pre_cnt = pre_cnt + 1;
        if (cs_o) cs_seen = 1;
        sk_prev = sk_o;
        man_prev = man_o;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [5:0] a);
        edge_cnt = 0; frame = '0; hmin = 1000; hmax = 0; hi_run = 0;
        pre_cnt = 0; cs_seen = 0; arm_ok = 1; do_i = 1'b0;
        cur_word = mem_word(a);
        start_i = 1'b1; op_i = op; addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1, "R8 start accepted busy", busy_o, 1);
    endtask

    task automatic finish_txn(input logic [1:0] op, input logic [5:0] a);
        int n = 0;
        while (!done_o && n < 5000) begin @(negedge clk); n++; end
        chk(done_o === 1'b1, "R6 done reached", done_o, 1);
        chk(busy_o === 1'b0 && cs_o === 1'b0 && di_o === 1'b1, "R6 closed at done",
            {busy_o, cs_o, di_o}, 3'b001);
        chk(frame === exp_frame(op, a), "R1 frame bits", frame, exp_frame(op, a));
        if (op == 2'b10) begin
            exp_rdata = mem_word(a);
            chk(edge_cnt == 25, "R4 read pulse count", edge_cnt, 25);
            chk(rdata_o === exp_rdata, "R4 read word", rdata_o, exp_rdata);
        end else begin
            chk(edge_cnt == 9, "R5 pulse count", edge_cnt, 9);
            chk(rdata_o === exp_rdata, "R5 rdata kept", rdata_o, exp_rdata);
        end
        chk(hmin == HALF && hmax == HALF, "R10 high width", hmax, HALF);
        chk(arm_ok && pre_cnt == HALF, "R2 arm phase", pre_cnt, HALF);
    endtask

    initial begin
        void'($urandom(32'h1F2E));
        repeat (3) @(negedge clk);
        chk(busy_o === 0 && done_o === 0 && rdata_o === 16'h0, "R9 reset outputs",
            {busy_o, done_o, rdata_o}, 0);
        chk(man_o === 0 && cs_o === 0 && sk_o === 0 && di_o === 1, "R9 R7 parked pins",
            {man_o, cs_o, sk_o, di_o}, 4'b0001);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: each extended sub-code and edge addresses
        issue(2'b00, 6'h30); finish_txn(2'b00, 6'h30);
        issue(2'b00, 6'h00); finish_txn(2'b00, 6'h00);
        issue(2'b10, 6'h3F); finish_txn(2'b10, 6'h3F);
        issue(2'b01, 6'h00); finish_txn(2'b01, 6'h00);
        issue(2'b11, 6'h15); finish_txn(2'b11, 6'h15);
        issue(2'b10, 6'h00); finish_txn(2'b10, 6'h00);
        issue(2'b00, 6'h20); finish_txn(2'b00, 6'h20);
        issue(2'b00, 6'h10); finish_txn(2'b00, 6'h10);

        // R8: start while busy is ignored
        repeat (2) @(negedge clk);
        issue(2'b10, 6'h2A);
        repeat (30) @(negedge clk);
        start_i = 1'b1; op_i = 2'b11; addr_i = 6'h3F;
        @(negedge clk);
        start_i = 1'b0;
        finish_txn(2'b10, 6'h2A);
        repeat (4) @(negedge clk);
        chk(man_o === 0 && busy_o === 0, "R8 no extra access", {man_o, busy_o}, 0);
        chk(edge_cnt == 25, "R8 pulse count unchanged", edge_cnt, 25);

        // random mix, zero gap gives start in the done cycle
        for (int k = 0; k < 24; k++) begin
            logic [1:0] op = 2'($urandom_range(0, 3));
            logic [5:0] a  = 6'($urandom_range(0, 63));
            int gap = $urandom_range(0, 2);
            if (op == 2'b00) a = {a[1:0], 4'h0};
            repeat (gap) @(negedge clk);
            issue(op, a);
            finish_txn(op, a);
        end

        repeat (3) @(negedge clk);
        chk(man_o === 0 && cs_o === 0 && sk_o === 0 && di_o === 1, "R7 parked after run",
            {man_o, cs_o, sk_o, di_o}, 4'b0001);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule